// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block steps a shared-datapath processor through each instruction one phase per clock. It is a Moore machine with ten steps. Every instruction starts with a fetch step and a decode step. After decode, the 6-bit opcode chooses one of five paths: register ALU operation, word load, word store, branch on equal, or jump. Branch and jump finish in their third cycle. Register operations and stores take four cycles, and loads take five.

The controller reads only clock, reset and opcode. It drives every enable and multiplexer select that the datapath needs for the current step: memory strobes, the address source, the instruction and program-counter write enables, the ALU operand and operation selects, and the register-file write controls. All control outputs are registered. The active step number is also exported so that a test environment can observe the sequence.

Top module: `mc_seq_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the controller enters step 0 with the fetch control word. This reset is synchronous and works from any step.
- R2: Step 0 drives `mem_rd`, `ir_we` and `pc_we` high. It sets `alu_b_sel`=01 and drives `addr_sel`, `alu_a_sel`, `alu_op` and `pc_src` to 0. The next step is always step 1.
- R3: Step 1 sets `alu_b_sel`=11, with `alu_a_sel`=0, `alu_op`=00 and no enable active. It then dispatches on `opcode`: 100011 (load) and 101011 (store) go to step 2, 000000 (register ALU) goes to step 6, 000100 (branch on equal) goes to step 8, and 000010 (jump) goes to step 9.
- R4: A load follows steps 0,1,2,3,4,0. Step 2 sets `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. Step 3 drives `mem_rd` with `addr_sel`=1. Step 4 drives `rf_we` with `rf_wdata_sel`=1 and `rf_dst_sel`=0. After step 2, `opcode` is ignored.
- R5: A store follows steps 0,1,2,5,0. Step 5 drives `mem_wr` with `addr_sel`=1.
- R6: A register ALU operation follows steps 0,1,6,7,0. Step 6 sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. Step 7 drives `rf_we` with `rf_dst_sel`=1 and `rf_wdata_sel`=0.
- R7: A branch on equal follows steps 0,1,8,0. Step 8 sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01, and drives `pc_we_cond` with `pc_src`=01.
- R8: A jump follows steps 0,1,9,0. Step 9 drives `pc_we` with `pc_src`=10.
- R9: Any other opcode seen in step 1 sends the controller back to step 0.
- R10: In every step, each enable and select that the step does not name is 0. `mem_rd` and `mem_wr` are never high together, and `rf_we` is high only in steps 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write qualified by ALU zero |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 extended immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |
| rf_wdata_sel | output | 1 | Write data: 0 ALU result register, 1 memory data register |
| step | output | 4 | Current step number, 0 to 9 |

## Verification
The step register and the registered control word both update on the same rising edge. Each output therefore shows the new step's values exactly one edge after the step it came from, and the opcode only matters at the edges that leave steps 1 and 2. The bench applies an opcode while the controller is in step 0 and holds it. It then samples every output at the falling edge after each rising edge and compares it with the word expected for that step. For the ignore case, the opcode is changed during step 3 of a load, and the step 4 outputs are checked to show the change had no effect.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  localparam int STEP_W = 4;
  localparam int OPC_W  = 6;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STMEM  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_we;
    logic       pc_we;
    logic       pc_we_cond;
    logic [1:0] pc_src;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       rf_we;
    logic       rf_dst_sel;
    logic       rf_wdata_sel;
  } ctrl_t;
endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
  import mc_seq_pkg::*;
(
  input  step_e             cur,
  input  logic [OPC_W-1:0]  opcode,
  output step_e             nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_ADDR;
        else if (opcode == OPC_RTYPE)                  nxt = ST_EXEC;
        else if (opcode == OPC_BEQ)                    nxt = ST_BRANCH;
        else if (opcode == OPC_JUMP)                   nxt = ST_JUMP;
        else                                           nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_STMEM : ST_LDMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_seq_decode.sv
module mc_seq_decode
  import mc_seq_pkg::*;
(
  input  step_e st,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    case (st)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_we     = 1'b1;
        ctrl.pc_we     = 1'b1;
        ctrl.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctrl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = 2'b10;
      end
      ST_LDMEM: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_we        = 1'b1;
        ctrl.rf_wdata_sel = 1'b1;
      end
      ST_STMEM: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      ST_RWB: begin
        ctrl.rf_we      = 1'b1;
        ctrl.rf_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_op     = 2'b01;
        ctrl.pc_we_cond = 1'b1;
        ctrl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_we  = 1'b1;
        ctrl.pc_src = 2'b10;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_we,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic [1:0]       pc_src,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             rf_we,
  output logic             rf_dst_sel,
  output logic             rf_wdata_sel,
  output logic [STEP_W-1:0] step
);
  step_e state_q, nxt, target;
  ctrl_t ctrl_q, ctrl_d;

  mc_seq_next u_next (.cur(state_q), .opcode(opcode), .nxt(nxt));

  assign target = rst ? ST_FETCH : nxt;

  mc_seq_decode u_dec (.st(target), .ctrl(ctrl_d));

  always_ff @(posedge clk) begin
    state_q <= target;
    ctrl_q  <= ctrl_d;
  end

  assign mem_rd       = ctrl_q.mem_rd;
  assign mem_wr       = ctrl_q.mem_wr;
  assign addr_sel     = ctrl_q.addr_sel;
  assign ir_we        = ctrl_q.ir_we;
  assign pc_we        = ctrl_q.pc_we;
  assign pc_we_cond   = ctrl_q.pc_we_cond;
  assign pc_src       = ctrl_q.pc_src;
  assign alu_a_sel    = ctrl_q.alu_a_sel;
  assign alu_b_sel    = ctrl_q.alu_b_sel;
  assign alu_op       = ctrl_q.alu_op;
  assign rf_we        = ctrl_q.rf_we;
  assign rf_dst_sel   = ctrl_q.rf_dst_sel;
  assign rf_wdata_sel = ctrl_q.rf_wdata_sel;
  assign step         = state_q;

  a_r1_reset_to_fetch: assert property (@(posedge clk) rst |=> (step == 4'd0 && ir_we));
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd0) |=> (step == 4'd1));
  a_r4_load_writeback: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd3) |=> (step == 4'd4 && rf_we && rf_wdata_sel));
  a_r7_branch_returns: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd8) |=> (step == 4'd0));
  a_r9_unknown_op: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd1 && opcode != OPC_RTYPE && opcode != OPC_LOAD && opcode != OPC_STORE
     && opcode != OPC_BEQ && opcode != OPC_JUMP) |=> (step == 4'd0));
  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  a_r10_rf_we_steps: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (step == 4'd4 || step == 4'd7));
endmodule

// File: tb/mc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mc_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  logic alu_a_sel, rf_we, rf_dst_sel, rf_wdata_sel;
  logic [3:0] step;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src(pc_src),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel),
    .step(step)
  );

  // {mem_rd,mem_wr,addr_sel,ir_we,pc_we,pc_we_cond,pc_src,alu_a,alu_b,alu_op,rf_we,dst,wdata}
  function automatic logic [15:0] exp_word(int s);
    logic rd = 0, wr = 0, ad = 0, ir = 0, pw = 0, pc = 0, a = 0, rw = 0, ds = 0, wd = 0;
    logic [1:0] ps = 0, b = 0, op = 0;
    case (s)
      0: begin rd = 1; ir = 1; pw = 1; b = 2'b01; end
      1: b = 2'b11;
      2: begin a = 1; b = 2'b10; end
      3: begin rd = 1; ad = 1; end
      4: begin rw = 1; wd = 1; end
      5: begin wr = 1; ad = 1; end
      6: begin a = 1; op = 2'b10; end
      7: begin rw = 1; ds = 1; end
      8: begin a = 1; op = 2'b01; pc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {rd, wr, ad, ir, pw, pc, ps, a, b, op, rw, ds, wd};
  endfunction

  function automatic logic [15:0] got_word();
    return {mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond, pc_src,
            alu_a_sel, alu_b_sel, alu_op, rf_we, rf_dst_sel, rf_wdata_sel};
  endfunction

  task automatic check_step(int s, string req);
    n_chk++;
    if (step !== 4'(s) || got_word() !== exp_word(s)) begin
      n_err++;
      $display("FAIL %s: step=%0d ctrl=%b expected step=%0d ctrl=%b",
               req, step, got_word(), s, exp_word(s));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    tick();
    check_step(0, "R1 reset");
    rst = 1'b0;
  endtask

  task automatic t_load();
    opcode = 6'b100011;
    tick(); check_step(1, "R2 fetch to decode");
    tick(); check_step(2, "R3 load dispatch");
    tick(); check_step(3, "R4 load memory");
    opcode = 6'b101011; // R4: opcode changed after step 2 must be ignored
    tick(); check_step(4, "R4 load writeback");
    tick(); check_step(0, "R4 load return");
  endtask

  task automatic t_store();
    opcode = 6'b101011;
    tick(); check_step(1, "R3 decode");
    tick(); check_step(2, "R5 store address");
    tick(); check_step(5, "R5 store write");
    tick(); check_step(0, "R5 store return");
  endtask

  task automatic t_rtype();
    opcode = 6'b000000;
    tick(); check_step(1, "R3 decode");
    tick(); check_step(6, "R6 execute");
    tick(); check_step(7, "R6 writeback");
    tick(); check_step(0, "R6 return");
  endtask

  task automatic t_beq();
    opcode = 6'b000100;
    tick(); check_step(1, "R3 decode");
    tick(); check_step(8, "R7 branch");
    tick(); check_step(0, "R7 return");
  endtask

  task automatic t_jump();
    opcode = 6'b000010;
    tick(); check_step(1, "R3 decode");
    tick(); check_step(9, "R8 jump");
    tick(); check_step(0, "R8 return");
  endtask

  task automatic t_unknown(logic [5:0] op);
    opcode = op;
    tick(); check_step(1, "R3 decode");
    tick(); check_step(0, "R9 unknown opcode");
  endtask

  task automatic t_reset_mid();
    opcode = 6'b000000;
    tick(); check_step(1, "R3 decode");
    tick(); check_step(6, "R6 execute");
    rst = 1'b1;
    tick(); check_step(0, "R1 reset from step 6");
    rst = 1'b0;
    tick(); check_step(1, "R1 resume after reset");
    opcode = 6'b111111;
    tick(); check_step(0, "R9 unknown after reset");
  endtask

  initial begin
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_beq();
    t_jump();
    t_unknown(6'b111111);
    t_unknown(6'b100010);
    t_reset_mid();
    t_load(); // R10 checked in every step via full control word
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule